// File: doc/BRIEF.md
# LPDDR2 Power-Up Command Sequencer

This block walks a freshly powered LPDDR2 device through its bring-up. After a start request it issues a fixed, ordered series of commands toward a command port. The series contains idle (NOP) commands, a device reset done as a mode-register write, a ZQ calibration write, and a set of mode-register writes. Programmed pauses are placed between the early commands. Each command is presented with a valid flag and held until the memory-side port accepts it with a ready flag.

Two side outputs accompany the command stream. One selects the ZQ calibration type: reset type until the calibration write has been accepted, short type afterwards. The other enables the input buffers: it opens one cycle before the second group of mode-register writes and closes after the normal-mode command. The mode-register data values, the data path and refresh after bring-up are handled elsewhere. When the buffers have closed, a done flag rises and stays high until the next start.

States:
- `ST_IDLE`: reset state.
- `ST_ISSUE`: a command is valid.
- `ST_PAUSE`: a timed gap after an accepted command.
- `ST_BUF_ON`: one cycle that opens the input buffers.
- `ST_BUF_OFF`: one cycle that closes them.
- `ST_DONE`: the sequence is complete.

Transitions:
- IDLE→ISSUE and DONE→ISSUE on start.
- ISSUE→PAUSE on acceptance of a step that carries a pause.
- PAUSE→ISSUE when the pause timer reaches zero.
- ISSUE→ISSUE on acceptance of an ordinary step.
- ISSUE→BUF_ON on acceptance of the fourth write after calibration.
- BUF_ON→ISSUE unconditionally.
- ISSUE→BUF_OFF on acceptance of the normal-mode command.
- BUF_OFF→DONE unconditionally.

Top module: `lpddr2_init_seq`

## Requirements
- R1: After reset, `cmd_valid_o`, `done_o`, `ibuf_en_o` and `zq_short_o` are 0, and `cmd_code_o` and `cmd_mra_o` are 0.
- R2: A start pulse in the idle or done state begins the sequence. A command stays valid, with its code and address unchanged, until `cmd_ready_i` is high at a clock edge.
- R3: The accepted commands, in order, are exactly 14. Codes are 1 = NOP, 2 = mode-register write (MRW), 3 = normal mode, and 0 = no command. The order is: NOP, NOP, MRW 63, MRW 10, MRW 1, MRW 2, MRW 3, MRW 16, NOP, MRW 5, MRW 6, MRW 8, MRW 0, NORMAL. Non-MRW commands carry address 0.
- R4: Timed pauses follow three commands. After the first NOP is accepted, `cmd_valid_o` stays low for exactly SHORT_PAUSE_CYC cycles. After the second NOP it stays low for RESET_PAUSE_CYC cycles. After MRW 63 it stays low for INIT5_PAUSE_CYC cycles. Every other command is valid in the cycle after its predecessor is accepted, apart from the buffer-open cycle of R6.
- R5: `zq_short_o` is 0 up to and including the cycle in which MRW 10 is accepted, and 1 from the next cycle until a restart.
- R6: `ibuf_en_o` rises in a cycle with no valid command, immediately before the NOP that follows MRW 16. It is high for every command from that NOP through NORMAL, and it is 0 in the cycle after NORMAL is accepted.
- R7: `done_o` rises two cycles after NORMAL is accepted, one cycle after the buffers close. It then stays high with no command valid until the next start.
- R8: A start pulse while the sequence is running is ignored: the command list and its timing are unchanged.
- R9: A start pulse while done is high clears `done_o` in the next cycle, returns `zq_short_o` to 0, and repeats the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| cmd_ready_i | input | 1 | Command port accepts the current command |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_code_o | output | 3 | Command code (0 none, 1 NOP, 2 MRW, 3 normal) |
| cmd_mra_o | output | 8 | Mode-register address of an MRW |
| zq_short_o | output | 1 | ZQ type: 0 reset, 1 short |
| ibuf_en_o | output | 1 | Input-buffer enable |
| done_o | output | 1 | Sequence complete |

## Verification
The hardest situation to reach from the ports is a start request that lands while the sequence is in the middle of a timed pause. The command port is quiet then, so the request leaves no visible trace. The stimulus places a start pulse a fixed number of cycles after launch, inside the long pre-reset pause, and then compares the full list of accepted commands and every gap against the undisturbed case. A second pass holds ready low for several cycles on every command, so that commands must be held and the pauses must stack correctly with the stalls.

// File: rtl/lpddr2_init_pkg.sv
package lpddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_NOP    = 3'd1,
        CMD_MRW    = 3'd2,
        CMD_NORMAL = 3'd3
    } cmd_code_e;

    typedef enum logic [1:0] {
        PZ_NONE  = 2'd0,
        PZ_SHORT = 2'd1,
        PZ_RESET = 2'd2,
        PZ_INIT5 = 2'd3
    } pause_sel_e;

    typedef struct packed {
        cmd_code_e  code;
        logic [7:0] mra;
        pause_sel_e pause;
    } step_t;

    localparam int NUM_STEPS      = 14;
    localparam int STEP_W         = $clog2(NUM_STEPS);
    localparam int ZQ_SHORT_STEP  = 4;   // first step issued with short ZQ type
    localparam int BUF_OPEN_AFTER = 7;   // step after which buffers open
    localparam int IBUF_FIRST     = 8;   // first step issued with buffers open

endpackage

// File: rtl/lpddr2_step_table.sv
module lpddr2_step_table
    import lpddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o
);

    function automatic step_t mk(cmd_code_e c, int unsigned a, pause_sel_e p);
        step_t s;
        s.code  = c;
        s.mra   = 8'(a);
        s.pause = p;
        return s;
    endfunction

    always_comb begin
        unique case (idx_i)
            4'd0:    step_o = mk(CMD_NOP,    0,  PZ_SHORT);
            4'd1:    step_o = mk(CMD_NOP,    0,  PZ_RESET);
            4'd2:    step_o = mk(CMD_MRW,    63, PZ_INIT5);
            4'd3:    step_o = mk(CMD_MRW,    10, PZ_NONE);
            4'd4:    step_o = mk(CMD_MRW,    1,  PZ_NONE);
            4'd5:    step_o = mk(CMD_MRW,    2,  PZ_NONE);
            4'd6:    step_o = mk(CMD_MRW,    3,  PZ_NONE);
            4'd7:    step_o = mk(CMD_MRW,    16, PZ_NONE);
            4'd8:    step_o = mk(CMD_NOP,    0,  PZ_NONE);
            4'd9:    step_o = mk(CMD_MRW,    5,  PZ_NONE);
            4'd10:   step_o = mk(CMD_MRW,    6,  PZ_NONE);
            4'd11:   step_o = mk(CMD_MRW,    8,  PZ_NONE);
            4'd12:   step_o = mk(CMD_MRW,    0,  PZ_NONE);
            4'd13:   step_o = mk(CMD_NORMAL, 0,  PZ_NONE);
            default: step_o = mk(CMD_NONE,   0,  PZ_NONE);
        endcase
    end

endmodule

// File: rtl/lpddr2_pause_timer.sv
module lpddr2_pause_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lpddr2_init_seq.sv
module lpddr2_init_seq
    import lpddr2_init_pkg::*;
#(
    parameter int SHORT_PAUSE_CYC = 25,
    parameter int RESET_PAUSE_CYC = 50000,
    parameter int INIT5_PAUSE_CYC = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cmd_ready_i,
    output logic       cmd_valid_o,
    output logic [2:0] cmd_code_o,
    output logic [7:0] cmd_mra_o,
    output logic       zq_short_o,
    output logic       ibuf_en_o,
    output logic       done_o
);

    localparam int MAX_A   = (SHORT_PAUSE_CYC > RESET_PAUSE_CYC) ? SHORT_PAUSE_CYC : RESET_PAUSE_CYC;
    localparam int MAX_P   = (MAX_A > INIT5_PAUSE_CYC) ? MAX_A : INIT5_PAUSE_CYC;
    localparam int CNT_W   = $clog2(MAX_P + 1);
    localparam int SHORT_L = (SHORT_PAUSE_CYC > 0) ? SHORT_PAUSE_CYC - 1 : 0;
    localparam int RESET_L = (RESET_PAUSE_CYC > 0) ? RESET_PAUSE_CYC - 1 : 0;
    localparam int INIT5_L = (INIT5_PAUSE_CYC > 0) ? INIT5_PAUSE_CYC - 1 : 0;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_PAUSE,
        ST_BUF_ON,
        ST_BUF_OFF,
        ST_DONE
    } state_e;

    state_e            state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    step_t             cur;
    logic              accept;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    lpddr2_step_table u_table (
        .idx_i  (step_q),
        .step_o (cur)
    );

    lpddr2_pause_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (state_q == ST_PAUSE),
        .zero_o     (tmr_zero)
    );

    assign accept = (state_q == ST_ISSUE) && cmd_ready_i;

    always_comb begin
        unique case (cur.pause)
            PZ_SHORT: tmr_val = CNT_W'(SHORT_L);
            PZ_RESET: tmr_val = CNT_W'(RESET_L);
            PZ_INIT5: tmr_val = CNT_W'(INIT5_L);
            default:  tmr_val = '0;
        endcase
        tmr_load = accept && (cur.pause != PZ_NONE);
    end

    // next-state and step selection
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_ISSUE;
                    step_d  = '0;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready_i) begin
                    if (cur.pause != PZ_NONE) begin
                        state_d = ST_PAUSE;
                    end else if (step_q == LAST_STEP) begin
                        state_d = ST_BUF_OFF;
                    end else if (step_q == STEP_W'(BUF_OPEN_AFTER)) begin
                        state_d = ST_BUF_ON;
                        step_d  = step_q + 1'b1;
                    end else begin
                        step_d  = step_q + 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (tmr_zero) begin
                    state_d = ST_ISSUE;
                    step_d  = step_q + 1'b1;
                end
            end
            ST_BUF_ON:  state_d = ST_ISSUE;
            ST_BUF_OFF: state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // outputs
    always_comb begin
        cmd_valid_o = (state_q == ST_ISSUE);
        cmd_code_o  = cmd_valid_o ? cur.code : CMD_NONE;
        cmd_mra_o   = cmd_valid_o ? cur.mra : 8'd0;
        zq_short_o  = (state_q != ST_IDLE) && (step_q >= STEP_W'(ZQ_SHORT_STEP));
        ibuf_en_o   = (state_q == ST_BUF_ON) ||
                      (((state_q == ST_ISSUE) || (state_q == ST_PAUSE)) &&
                       (step_q >= STEP_W'(IBUF_FIRST)));
        done_o      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/lpddr2_init_chk.sv
module lpddr2_init_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cmd_ready_i,
    input logic       cmd_valid_o,
    input logic [2:0] cmd_code_o,
    input logic [7:0] cmd_mra_o,
    input logic       zq_short_o,
    input logic       ibuf_en_o,
    input logic       done_o
);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_mra_o)); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_code_o != 3'd0) && (cmd_code_o <= 3'd3)); // R3

    AST_RESET_WRITE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && (cmd_code_o == 3'd2) && (cmd_mra_o == 8'd63) |-> !zq_short_o && !ibuf_en_o); // R5

    AST_ZQ_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zq_short_o) |-> $past(start_i)); // R9

    AST_IBUF_OPEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibuf_en_o) |-> !cmd_valid_o); // R6

    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !$past(ibuf_en_o) && !ibuf_en_o); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_valid_o); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o); // R7

endmodule

bind lpddr2_init_seq lpddr2_init_chk u_chk (.*);

// File: tb/lpddr2_init_seq_tb.sv
`timescale 1ns/1ps
module lpddr2_init_seq_tb;

    localparam int P_SHORT = 3;
    localparam int P_RESET = 20;
    localparam int P_INIT5 = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cmd_ready_i = 1'b0;
    logic       cmd_valid_o;
    logic [2:0] cmd_code_o;
    logic [7:0] cmd_mra_o;
    logic       zq_short_o, ibuf_en_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int log_code [0:31];
    int log_mra  [0:31];
    int log_zq   [0:31];
    int log_ibuf [0:31];
    int log_at   [0:31];
    int nlog;
    int done_at, ibuf_before_done, ibuf_at_done, done_first;

    always #2 clk = ~clk;

    lpddr2_init_seq #(
        .SHORT_PAUSE_CYC (P_SHORT),
        .RESET_PAUSE_CYC (P_RESET),
        .INIT5_PAUSE_CYC (P_INIT5)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmd_ready_i (cmd_ready_i),
        .cmd_valid_o (cmd_valid_o), .cmd_code_o (cmd_code_o), .cmd_mra_o (cmd_mra_o),
        .zq_short_o (zq_short_o), .ibuf_en_o (ibuf_en_o), .done_o (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(int i);
        if (i == 0 || i == 1 || i == 8) return 1;
        if (i == 13) return 3;
        return 2;
    endfunction

    function automatic int exp_mra(int i);
        case (i)
            2: return 63;   3: return 10;  4: return 1;  5: return 2;
            6: return 3;    7: return 16;  9: return 5;  10: return 6;
            11: return 8;   default: return 0;
        endcase
    endfunction

    function automatic int exp_pause(int i);
        case (i)
            0: return P_SHORT;
            1: return P_RESET;
            2: return P_INIT5;
            default: return 0;
        endcase
    endfunction

    // launch a sequence and act as the command port until done
    task automatic run_seq(input int stall, input int inject_at);
        int n = 0;
        int wait_cnt = 0;
        int prev_ibuf = 0;
        nlog = 0; done_at = -1; done_first = -1;
        @(negedge clk);
        start_i = 1'b1;
        while (n < 2000) begin
            @(negedge clk);
            n++;
            start_i = (n == inject_at);
            if (n == 1) done_first = done_o;
            if (done_o) begin
                done_at = n;
                ibuf_before_done = prev_ibuf;
                ibuf_at_done = ibuf_en_o;
                cmd_ready_i = 1'b0;
                break;
            end
            prev_ibuf = ibuf_en_o;
            if (cmd_valid_o) begin
                if (wait_cnt >= stall) begin
                    cmd_ready_i = 1'b1;
                    if (nlog < 32) begin
                        log_code[nlog] = cmd_code_o;
                        log_mra[nlog]  = cmd_mra_o;
                        log_zq[nlog]   = zq_short_o;
                        log_ibuf[nlog] = ibuf_en_o;
                        log_at[nlog]   = n;
                    end
                    nlog++;
                    wait_cnt = 0;
                end else begin
                    cmd_ready_i = 1'b0;
                    wait_cnt++;
                end
            end else begin
                cmd_ready_i = 1'b0;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic check_seq(input int stall, input string tag);
        chk(nlog == 14, {"R3 count ", tag}, nlog, 14);
        if (nlog == 14) begin
            for (int i = 0; i < 14; i++) begin
                chk(log_code[i] == exp_code(i), {"R3 code ", tag}, log_code[i], exp_code(i));
                chk(log_mra[i] == exp_mra(i), {"R3 mra ", tag}, log_mra[i], exp_mra(i));
                chk(log_zq[i] == ((i >= 4) ? 1 : 0), {"R5 zq ", tag}, log_zq[i], (i >= 4) ? 1 : 0);
                chk(log_ibuf[i] == ((i >= 8) ? 1 : 0), {"R6 ibuf ", tag}, log_ibuf[i], (i >= 8) ? 1 : 0);
                if (i > 0) begin
                    int eg = 1 + stall + exp_pause(i - 1) + ((i - 1 == 7) ? 1 : 0);
                    chk(log_at[i] - log_at[i-1] == eg, {"R4 gap ", tag}, log_at[i] - log_at[i-1], eg);
                end
            end
            chk(done_at - log_at[13] == 2, {"R7 done timing ", tag}, done_at - log_at[13], 2);
        end
        chk(ibuf_before_done == 0, {"R6 ibuf closed ", tag}, ibuf_before_done, 0);
        chk(ibuf_at_done == 0, {"R7 ibuf at done ", tag}, ibuf_at_done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_valid_o == 0, "R1 valid", cmd_valid_o, 0);
        chk(done_o == 0, "R1 done", done_o, 0);
        chk(ibuf_en_o == 0, "R1 ibuf", ibuf_en_o, 0);
        chk(zq_short_o == 0, "R1 zq", zq_short_o, 0);
        chk(cmd_code_o == 0 && cmd_mra_o == 0, "R1 code/mra", cmd_code_o, 0);
    endtask

    task automatic t_basic();
        run_seq(0, -1);
        check_seq(0, "basic");
    endtask

    task automatic t_done_hold();
        repeat (6) @(negedge clk);
        chk(done_o == 1, "R7 done holds", done_o, 1);
        chk(cmd_valid_o == 0, "R7 no cmd while done", cmd_valid_o, 0);
    endtask

    task automatic t_stall();
        run_seq(3, -1);
        check_seq(3, "stall R2");
    endtask

    task automatic t_restart();
        run_seq(0, -1);
        chk(done_first == 0, "R9 done cleared", done_first, 0);
        chk(log_zq[0] == 0, "R9 zq back to reset type", log_zq[0], 0);
        check_seq(0, "restart R9");
    endtask

    task automatic t_ignore_start();
        run_seq(0, 10);   // lands inside the reset pause
        check_seq(0, "start ignored R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_done_hold();
        t_stall();
        t_restart();
        t_ignore_start();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule